// File: doc/BRIEF.md
# Configurable Edge and Quadrature Counter

This block is a position and event counter driven by two raw input pins, A and B. In plain counting mode it counts up on the chosen edges of pin A and ignores pin B. In quadrature mode it decodes the A/B pair as an incremental encoder and counts up or down.

A two-bit edge selection does two jobs. It picks the active edge of A in plain mode. It sets the decode resolution (two or four counts per encoder cycle) in quadrature mode. The count runs from zero to a programmable ceiling and wraps at either end. Each wrap gives a one-cycle flag.

The mode, edge selection and ceiling are captured only while the counter is disabled. Software sets them up, enables the counter, and then reads the position. There is no streaming data path, so every pin is a plain control or status signal with no handshake.

Top module: `edge_quad_counter`

## Requirements
- R1: After reset the count is 0, the wrap flag is low, the captured mode is plain counting with rising edges, and the captured ceiling is all ones, even if the counter is enabled straight out of reset.
- R2: In plain mode (quad_mode=0) the count only ever increments. It advances by one for each change of A whose new level matches edge_sel, where 0 means rising only, 1 means falling only and 2 means both.
- R3: In plain mode a change on pin B alone never alters the count.
- R4: In quadrature mode with edge_sel=2, each single-pin change counts. The sequence {A,B} 00,10,11,01,00 counts up and the reverse sequence counts down, giving four counts per encoder cycle.
- R5: In quadrature mode with edge_sel 0 or 1, only those single-pin changes count whose new level is 1 (for 0) or 0 (for 1), with the same direction rule as R4. This gives two counts per encoder cycle.
- R6: In quadrature mode, a sample in which A and B both change leaves the count unchanged.
- R7: An up step taken at or above the ceiling loads 0 and raises wrap for exactly that cycle.
- R8: A down step taken at 0 loads the ceiling and raises wrap for exactly that cycle.
- R9: Mode, edge_sel and ceiling are captured on every clock edge where enable is low, and ignored otherwise. This includes the edge on which enable is first seen high.
- R10: While enable is low the count holds, and pin changes made while disabled are never counted afterwards.
- R11: A pin change reaches the count on the third rising clock edge after it is applied, after passing two synchroniser stages and one edge-detection stage.
- R12: edge_sel=3 behaves exactly like edge_sel=2 in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_a | input | 1 | Raw input A (asynchronous) |
| pin_b | input | 1 | Raw input B (asynchronous) |
| quad_mode | input | 1 | 0 = plain up counting on A, 1 = quadrature decode |
| edge_sel | input | 2 | 0 rising, 1 falling, 2 or 3 both |
| ceiling | input | W | Highest count value before wrapping |
| enable | input | 1 | Counting enable; configuration is captured while low |
| count | output | W | Current count |
| wrap | output | 1 | One-cycle pulse on overflow or underflow |

## Verification
Two events can fall on the same clock edge. One is the configuration capture. The other is the enable transition that freezes that capture. The bench presents a new ceiling in the same cycle as the rising enable, and expects counting to wrap at the previously captured ceiling, not the new one.

A second collision occurs when a decoded step lands exactly on a boundary, so the increment and the wrap happen together. Gray-code sweeps in both directions with a small ceiling cross the boundary many times. The count and the number of wrap pulses are then compared against an arithmetic model.

// File: rtl/eqc_pkg.sv
package eqc_pkg;
  localparam logic [1:0] EDGE_RISE = 2'd0;
  localparam logic [1:0] EDGE_FALL = 2'd1;

  typedef struct packed {
    logic up;
    logic dn;
  } eqc_step_t;

  // Returns whether a pin arriving at new_lvl matches the selected edge.
  function automatic logic eqc_edge_match(input logic new_lvl, input logic [1:0] sel);
    if (sel == EDGE_RISE)      return new_lvl;
    else if (sel == EDGE_FALL) return !new_lvl;
    else                       return 1'b1;
  endfunction
endpackage

// File: rtl/eqc_sync.sv
module eqc_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/eqc_decode.sv
module eqc_decode
  import eqc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       s_a,
  input  logic       s_b,
  input  logic       quad,
  input  logic [1:0] edge_sel,
  output eqc_step_t  step
);
  logic p_a, p_b;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_a <= 1'b0;
      p_b <= 1'b0;
    end else begin
      p_a <= s_a;
      p_b <= s_b;
    end
  end

  logic chg_a, chg_b, single, lvl, fwd, hit;
  always_comb begin
    chg_a  = s_a ^ p_a;
    chg_b  = s_b ^ p_b;
    single = chg_a ^ chg_b;
    lvl    = chg_a ? s_a : s_b;
    fwd    = chg_a ? (s_a != s_b) : (s_a == s_b);
    hit    = single && eqc_edge_match(lvl, edge_sel);
    if (!quad) begin
      step.up = chg_a && eqc_edge_match(s_a, edge_sel);
      step.dn = 1'b0;
    end else begin
      step.up = hit && fwd;
      step.dn = hit && !fwd;
    end
  end

  p_b_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!quad && (s_a == p_a)) |-> !(step.up || step.dn));
  p_plain_up_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !quad |-> !step.dn);
  p_double_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (quad && (s_a != p_a) && (s_b != p_b)) |-> !(step.up || step.dn));
endmodule

// File: rtl/eqc_count.sv
module eqc_count
  import eqc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  eqc_step_t    step,
  input  logic [W-1:0] ceil_v,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      wrap <= 1'b0;
    end else begin
      wrap <= 1'b0;
      if (en && step.up) begin
        if (cnt >= ceil_v) begin
          cnt  <= '0;
          wrap <= 1'b1;
        end else begin
          cnt <= cnt + ONE;
        end
      end else if (en && step.dn) begin
        if (cnt == '0) begin
          cnt  <= ceil_v;
          wrap <= 1'b1;
        end else begin
          cnt <= cnt - ONE;
        end
      end
    end
  end

  p_hold_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt));
  p_wrap_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> (cnt == '0 || cnt == ceil_v));
  p_increment_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && step.up && cnt < ceil_v) |=> (cnt == $past(cnt) + ONE) && !wrap);
  p_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && step.dn && cnt == '0) |=> wrap);
endmodule

// File: rtl/edge_quad_counter.sv
module edge_quad_counter
  import eqc_pkg::*;
#(
  parameter int W         = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pin_a,
  input  logic         pin_b,
  input  logic         quad_mode,
  input  logic [1:0]   edge_sel,
  input  logic [W-1:0] ceiling,
  input  logic         enable,
  output logic [W-1:0] count,
  output logic         wrap
);
  logic         mode_q;
  logic [1:0]   edge_q;
  logic [W-1:0] ceil_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      edge_q <= EDGE_RISE;
      ceil_q <= '1;
    end else if (!enable) begin
      mode_q <= quad_mode;
      edge_q <= edge_sel;
      ceil_q <= ceiling;
    end
  end

  logic [1:0] synced;
  eqc_sync #(.WIDTH(2), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({pin_b, pin_a}), .q(synced)
  );

  eqc_step_t step;
  eqc_decode u_decode (
    .clk(clk), .rst_n(rst_n), .s_a(synced[0]), .s_b(synced[1]),
    .quad(mode_q), .edge_sel(edge_q), .step(step)
  );

  eqc_count #(.W(W)) u_count (
    .clk(clk), .rst_n(rst_n), .en(enable), .step(step),
    .ceil_v(ceil_q), .cnt(count), .wrap(wrap)
  );

  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> ($stable(ceil_q) && $stable(mode_q) && $stable(edge_q)));
endmodule

// File: tb/test_edge_quad_counter.sv
`timescale 1ns/1ps
module test_edge_quad_counter;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_a = 1'b0, pin_b = 1'b0, quad_mode = 1'b0, enable = 1'b1;
  logic [1:0] edge_sel = 2'd0;
  logic [W-1:0] ceiling = W'(3);
  logic [W-1:0] count;
  logic wrap;

  int n_cmp = 0, n_bad = 0, wraps_seen = 0;
  logic [W-1:0] m_cnt = '0, m_ceil = '1;
  logic m_mode = 1'b0;
  logic [1:0] m_edge = 2'd0;
  logic m_en = 1'b1;
  int m_wraps = 0;

  always #2.5 clk = ~clk;

  edge_quad_counter #(.W(W)) i_edge_quad_counter (
    .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b),
    .quad_mode(quad_mode), .edge_sel(edge_sel), .ceiling(ceiling),
    .enable(enable), .count(count), .wrap(wrap)
  );

  always @(negedge clk) if (rst_n && wrap) wraps_seen++;

  task automatic check(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic logic match(input logic lvl, input logic [1:0] e);
    return (e == 2'd0) ? lvl : (e == 2'd1) ? !lvl : 1'b1;
  endfunction

  // Model update for one sampled pin change.
  task automatic model(input logic pa, input logic pb, input logic na, input logic nb);
    logic da, db, up, dn, fwd, lvl;
    da = pa ^ na; db = pb ^ nb; up = 0; dn = 0;
    if (!m_mode) up = da && match(na, m_edge);
    else if (da ^ db) begin
      lvl = da ? na : nb;
      fwd = da ? (na != nb) : (na == nb);
      if (match(lvl, m_edge)) begin up = fwd; dn = !fwd; end
    end
    if (!m_en) return;
    if (up) begin
      if (m_cnt >= m_ceil) begin m_cnt = '0; m_wraps++; end else m_cnt = m_cnt + 1'b1;
    end else if (dn) begin
      if (m_cnt == '0) begin m_cnt = m_ceil; m_wraps++; end else m_cnt = m_cnt - 1'b1;
    end
  endtask

  task automatic drive(input logic na, input logic nb, input string req);
    @(negedge clk);
    model(pin_a, pin_b, na, nb);
    pin_a = na; pin_b = nb;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check({req, " count"}, int'(count), int'(m_cnt));
    check({req, " wraps"}, wraps_seen, m_wraps);
  endtask

  task automatic configure(input logic md, input logic [1:0] e, input logic [W-1:0] c);
    @(negedge clk);
    enable = 0; m_en = 0;
    quad_mode = md; edge_sel = e; ceiling = c;
    repeat (2) @(posedge clk);
    @(negedge clk);
    m_mode = md; m_edge = e; m_ceil = c;
    enable = 1; m_en = 1;
  endtask

  initial begin
    #200000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    string tag;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    check("R1 reset count", int'(count), 0);
    check("R1 reset wrap", int'(wrap), 0);
    // enabled out of reset: ceiling stays all ones, so 6 rising edges give 6
    for (int i = 0; i < 6; i++) begin
      drive(1, 0, "R1 default ceiling");
      drive(0, 0, "R1 default ceiling");
    end
    check("R1 no early wrap", int'(count), 6);

    // latency R11
    @(negedge clk); pin_a = 1; model(0, 0, 1, 0);
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R11 unchanged after 2 edges", int'(count), 6);
    @(posedge clk); @(negedge clk);
    check("R11 changed after 3 edges", int'(count), 7);
    drive(0, 0, "R11 settle");

    // sweep every mode and edge selection, both directions
    for (int md = 0; md < 2; md++) begin
      for (int e = 0; e < 4; e++) begin
        configure(md[0], e[1:0], W'(5));
        tag = (e == 3) ? "R12" : (md == 0) ? ((e == 2) ? "R2" : "R2") :
              (e == 2) ? "R4" : "R5";
        for (int k = 0; k < 12; k++)
          if (pin_a == pin_b) drive(!pin_a, pin_b, {tag, " fwd R7"});
          else drive(pin_a, !pin_b, {tag, " fwd R7"});
        for (int k = 0; k < 16; k++)
          if (pin_a == pin_b) drive(pin_a, !pin_b, {tag, " rev R8"});
          else drive(!pin_a, pin_b, {tag, " rev R8"});
        if (md == 0) begin
          drive(pin_a, !pin_b, "R3 B only");
          drive(pin_a, !pin_b, "R3 B only");
        end
      end
    end

    // R6 simultaneous change in quadrature
    configure(1, 2'd2, W'(9));
    drive(!pin_a, !pin_b, "R6 double change");
    drive(!pin_a, !pin_b, "R6 double change");

    // R10 disabled holds, changes not replayed
    @(negedge clk); enable = 0; m_en = 0;
    drive(!pin_a, pin_b, "R10 disabled");
    drive(pin_a, !pin_b, "R10 disabled");
    @(negedge clk); enable = 1; m_en = 1;
    repeat (3) @(posedge clk); @(negedge clk);
    check("R10 after re-enable", int'(count), int'(m_cnt));

    // R9 configuration ignored while enabled
    configure(0, 2'd0, W'(5));
    @(negedge clk); ceiling = W'(1); quad_mode = 1; edge_sel = 2'd1;
    for (int k = 0; k < 8; k++) begin
      drive(1, pin_b, "R9 frozen config");
      drive(0, pin_b, "R9 frozen config");
    end
    // R9 collision: new ceiling presented on the enabling edge is ignored
    @(negedge clk); enable = 0; m_en = 0; ceiling = W'(5); quad_mode = 0; edge_sel = 2'd0;
    repeat (2) @(posedge clk);
    @(negedge clk); enable = 1; m_en = 1; ceiling = W'(2);
    for (int k = 0; k < 7; k++) begin
      drive(1, pin_b, "R9 enable collision");
      drive(0, pin_b, "R9 enable collision");
    end

    // R7 count above a newly lowered ceiling goes to 0
    while (m_cnt != W'(4)) begin
      drive(1, pin_b, "R7 approach");
      drive(0, pin_b, "R7 approach");
    end
    configure(0, 2'd0, W'(2));
    drive(1, pin_b, "R7 above ceiling");
    check("R7 zero after overflow", int'(count), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule